// File: doc/BRIEF.md
# Byte and Halfword Rearrangement Unit

This is a purely combinational execution slice for a 64-bit integer pipeline. It decodes a 32-bit instruction word and applies one of five rearrangements to the 64-bit source operand, producing the result in the same cycle. The five operations are:

- a byte swap inside each halfword of the low word, with the word result sign-extended;
- the same byte swap across all four halfwords of the doubleword;
- a reversal of the halfword order in the doubleword;
- sign-extension from bit 7;
- sign-extension from bit 15.

The surrounding pipeline supplies the operand read for the source register field and writes the result to the destination field itself. This unit reads neither register index.

The operand and instruction travel together as one item qualified by `in_valid`. Because the unit has no state and always accepts, there is no ready signal and no back-pressure. Each item is answered combinationally while `in_valid` is high. When `in_valid` is low, every output is zero.

Top module: `bhr_unit`

## Requirements
- R1: An instruction is claimed only when bits 31:26 equal 011111 and the function field (bits 5:0) is 100000 or 100100. An operation is legal only when the rs field (bits 25:21) is also 00000. The shift-amount field is bits 10:6.
- R2: With shift amount 00010 and function 100000, the two bytes inside each halfword of src[31:0] are exchanged. The 32-bit result is sign-extended from its bit 31 into bits 63:32.
- R3: With shift amount 00010 and function 100100, the two bytes of every one of the four halfwords of src are exchanged independently. Halfword positions do not change.
- R4: With shift amount 00101 and function 100100, the halfword order is reversed. Halfword 3 (bits 63:48) moves to position 0, halfword 2 to position 1, halfword 1 to position 2, and halfword 0 to position 3.
- R5: With shift amount 10000 and function 100000, the result is src[7:0] with bit 7 replicated through bit 63.
- R6: With shift amount 11000 and function 100000, the result is src[15:0] with bit 15 replicated through bit 63.
- R7: A claimed instruction that is not one of the five legal encodings (nonzero rs, or any other shift amount) raises `res_illegal`, keeps `res_valid` low and drives `res` to zero.
- R8: An instruction that is not claimed leaves both flags low and `res` at zero.
- R9: While `in_valid` is low, both flags are low and `res` is zero, whatever the instruction.
- R10: For every legal operation, `res_valid` is high and `res` is correct in the same cycle the inputs are applied, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Qualifies instr and src |
| instr | input | 32 | Instruction word |
| src | input | 64 | Source operand |
| res | output | 64 | Result, zero unless res_valid |
| res_valid | output | 1 | Legal operation executed |
| res_illegal | output | 1 | Claimed but unrecognised encoding |

## Verification
The embedded immediate assertions take for granted that `in_valid`, `instr` and `src` carry known values whenever they are evaluated. The bench drives every input from a defined value at time zero and changes them only on the falling clock edge. All checks sample one nanosecond later, so a check never meets a half-applied item. Operands mix random values with zero, all ones and a pattern that sets only bits 63 and 7. These values make the sign-extension corners and the upper-word fill visible.

// File: rtl/bhr_pkg.sv
package bhr_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_WSWAP, OP_DSWAP, OP_HREV, OP_SEXTB, OP_SEXTH
  } bhr_op_e;

  localparam logic [5:0] MAJOR_OPC = 6'b011111;
  localparam logic [5:0] FN_WORD   = 6'b100000;
  localparam logic [5:0] FN_DWORD  = 6'b100100;
  localparam logic [4:0] SA_BSWAP  = 5'b00010;
  localparam logic [4:0] SA_HREV   = 5'b00101;
  localparam logic [4:0] SA_SEXTB  = 5'b10000;
  localparam logic [4:0] SA_SEXTH  = 5'b11000;
endpackage

// File: rtl/bhr_decode.sv
module bhr_decode
  import bhr_pkg::*;
(
  input  logic        in_valid,
  input  logic [31:0] instr,
  output bhr_op_e     op,
  output logic        illegal
);
  logic [5:0] opc, fn;
  logic [4:0] rs, sa;
  logic       claimed;
  logic [9:0] unused_reg_idx;

  assign opc = instr[31:26];
  assign rs  = instr[25:21];
  assign sa  = instr[10:6];
  assign fn  = instr[5:0];
  assign unused_reg_idx = instr[20:11];

  // R1: claim on major opcode plus one of the two functions
  assign claimed = in_valid && (opc == MAJOR_OPC) && ((fn == FN_WORD) || (fn == FN_DWORD));

  always_comb begin
    op = OP_NONE;
    if (claimed && rs == 5'd0) begin
      unique case ({fn, sa})
        {FN_WORD,  SA_BSWAP}: op = OP_WSWAP;
        {FN_DWORD, SA_BSWAP}: op = OP_DSWAP;
        {FN_DWORD, SA_HREV}:  op = OP_HREV;
        {FN_WORD,  SA_SEXTB}: op = OP_SEXTB;
        {FN_WORD,  SA_SEXTH}: op = OP_SEXTH;
        default:              op = OP_NONE;
      endcase
    end
  end

  assign illegal = claimed && (op == OP_NONE);

  always_comb begin
    a_r8_unclaimed_no_op: assert (claimed || (op == OP_NONE && !illegal));
  end
endmodule

// File: rtl/bhr_bswap.sv
module bhr_bswap #(
  parameter int W = 64
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NHALF = W / 16;
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign dout[16*h +: 8]     = din[16*h + 8 +: 8];
    assign dout[16*h + 8 +: 8] = din[16*h +: 8];
  end
endmodule

// File: rtl/bhr_hrev.sv
module bhr_hrev #(
  parameter int W = 64
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NHALF = W / 16;
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign dout[16*h +: 16] = din[16*(NHALF-1-h) +: 16];
  end
endmodule

// File: rtl/bhr_sext.sv
module bhr_sext #(
  parameter int XLEN = 64,
  parameter int FROM = 8
) (
  input  logic [XLEN-1:0] din,
  output logic [XLEN-1:0] dout
);
  localparam int FILL = XLEN - FROM;
  logic [FILL-1:0] unused_hi;
  assign unused_hi = din[XLEN-1:FROM];
  assign dout = {{FILL{din[FROM-1]}}, din[FROM-1:0]};
endmodule

// File: rtl/bhr_unit.sv
module bhr_unit
  import bhr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src,
  output logic [XLEN-1:0] res,
  output logic            res_valid,
  output logic            res_illegal
);
  localparam int UPPER = XLEN - WLEN;

  bhr_op_e         op;
  logic [WLEN-1:0] wswap;
  logic [XLEN-1:0] dswap, hrev, sextb, sexth;

  bhr_decode u_dec (.in_valid(in_valid), .instr(instr), .op(op), .illegal(res_illegal));
  bhr_bswap #(.W(WLEN)) u_wswap (.din(src[WLEN-1:0]), .dout(wswap));
  bhr_bswap #(.W(XLEN)) u_dswap (.din(src), .dout(dswap));
  bhr_hrev  #(.W(XLEN)) u_hrev  (.din(src), .dout(hrev));
  bhr_sext  #(.XLEN(XLEN), .FROM(8))  u_sextb (.din(src), .dout(sextb));
  bhr_sext  #(.XLEN(XLEN), .FROM(16)) u_sexth (.din(src), .dout(sexth));

  always_comb begin
    res = '0;
    unique case (op)
      OP_WSWAP: res = {{UPPER{wswap[WLEN-1]}}, wswap};
      OP_DSWAP: res = dswap;
      OP_HREV:  res = hrev;
      OP_SEXTB: res = sextb;
      OP_SEXTH: res = sexth;
      default:  res = '0;
    endcase
  end

  assign res_valid = (op != OP_NONE);

  always_comb begin
    a_r7_flags_exclusive: assert (!(res_valid && res_illegal));
    a_r7_illegal_zero:    assert (!res_illegal || res == '0);
    a_r9_idle_quiet:      assert (in_valid || (!res_valid && !res_illegal && res == '0));
    a_r5_byte_fill:       assert (!(res_valid && op == OP_SEXTB) ||
                                  res == {{(XLEN-8){src[7]}}, src[7:0]});
    a_r2_upper_fill:      assert (!(res_valid && op == OP_WSWAP) ||
                                  res[XLEN-1:WLEN] == {UPPER{src[WLEN-9]}});
    a_r4_hrev_involution: assert (!(res_valid && op == OP_HREV) ||
                                  res[15:0] == src[XLEN-1 -: 16]);
  end
endmodule

// File: tb/bhr_unit_bench.sv
module bhr_unit_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src = '0;
  logic [63:0] res;
  logic        res_valid, res_illegal;
  int total = 0, bad = 0;

  bhr_unit u_bhr_unit (.in_valid(in_valid), .instr(instr), .src(src),
                       .res(res), .res_valid(res_valid), .res_illegal(res_illegal));

  localparam logic [63:0] CORNER = 64'h8000_0000_0000_0080;

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rs,
                                     input logic [4:0] sa, input logic [5:0] fn);
    logic [4:0] rt = 5'($urandom);
    logic [4:0] rd = 5'($urandom);
    return {opc, rs, rt, rd, sa, fn};
  endfunction

  function automatic logic [63:0] m_wswap(input logic [63:0] s);
    logic [31:0] w = ((s[31:0] & 32'h00FF00FF) << 8) | ((s[31:0] >> 8) & 32'h00FF00FF);
    return {{32{w[31]}}, w};
  endfunction
  function automatic logic [63:0] m_dswap(input logic [63:0] s);
    return ((s & 64'h00FF00FF00FF00FF) << 8) | ((s >> 8) & 64'h00FF00FF00FF00FF);
  endfunction
  function automatic logic [63:0] m_hrev(input logic [63:0] s);
    logic [63:0] r = '0;
    for (int k = 0; k < 4; k++) r = (r << 16) | ((s >> (16*k)) & 64'hFFFF);
    return r;
  endfunction
  function automatic logic [63:0] m_sext(input logic [63:0] s, input int n);
    logic [63:0] m = (64'd1 << n) - 1;
    return s[n-1] ? (s | ~m) : (s & m);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [31:0] i, input logic [63:0] s);
    @(negedge clk);
    in_valid = v; instr = i; src = s;
    #1;
  endtask

  function automatic logic [63:0] pick(input int k);
    case (k)
      0: return 64'd0;
      1: return '1;
      2: return CORNER;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic t_reset();
    #1;
    chk("R9 reset res", res, 0);
    chk("R9 reset flags", {62'd0, res_valid, res_illegal}, 0);
  endtask

  // R2..R6, R10: each legal op over corners and random operands
  task automatic t_legal(input string tag, input logic [4:0] sa, input logic [5:0] fn, input int which);
    for (int k = 0; k < 12; k++) begin
      logic [63:0] s = pick(k);
      logic [63:0] e;
      case (which)
        0: e = m_wswap(s);
        1: e = m_dswap(s);
        2: e = m_hrev(s);
        3: e = m_sext(s, 8);
        default: e = m_sext(s, 16);
      endcase
      apply(1'b1, mk(6'b011111, 5'd0, sa, fn), s);
      chk(tag, res, e);
      chk({tag, " R10 valid"}, {63'd0, res_valid}, 1);
    end
  endtask

  task automatic t_illegal();
    apply(1'b1, mk(6'b011111, 5'd3, 5'b00010, 6'b100000), '1);
    chk("R7 rs nonzero res", res, 0);
    chk("R7 rs nonzero flags", {62'd0, res_valid, res_illegal}, 1);
    apply(1'b1, mk(6'b011111, 5'd0, 5'b00101, 6'b100000), CORNER);
    chk("R7 hrev under word fn", {res, 2'b00} | {64'd0, res_valid, res_illegal}, 66'd1);
    apply(1'b1, mk(6'b011111, 5'd0, 5'b10000, 6'b100100), '1);
    chk("R7 sextb under dword fn", {res, 2'b00} | {64'd0, res_valid, res_illegal}, 66'd1);
    apply(1'b1, mk(6'b011111, 5'd0, 5'b00000, 6'b100000), '1);
    chk("R7 zero sa", {62'd0, res_valid, res_illegal}, 1);
  endtask

  task automatic t_foreign();
    apply(1'b1, mk(6'b011110, 5'd0, 5'b00010, 6'b100000), '1);
    chk("R8 other opcode", {res, 2'b00} | {64'd0, res_valid, res_illegal}, 0);
    apply(1'b1, mk(6'b011111, 5'd0, 5'b00010, 6'b100001), '1);
    chk("R8 other function", {res, 2'b00} | {64'd0, res_valid, res_illegal}, 0);
  endtask

  task automatic t_idle();
    apply(1'b0, mk(6'b011111, 5'd0, 5'b10000, 6'b100000), '1);
    chk("R9 idle legal instr", {res, 2'b00} | {64'd0, res_valid, res_illegal}, 0);
    apply(1'b0, mk(6'b011111, 5'd7, 5'b10000, 6'b100000), '1);
    chk("R9 idle illegal instr", {62'd0, res_valid, res_illegal}, 0);
  endtask

  // R1: rs field position matters, rt/rd do not
  task automatic t_fields();
    apply(1'b1, {6'b011111, 5'd0, 5'd31, 5'd31, 5'b11000, 6'b100000}, 64'h0000_0000_0000_8001);
    chk("R1 rt/rd ignored", res, 64'hFFFF_FFFF_FFFF_8001);
    apply(1'b1, {6'b011111, 5'b10000, 5'd0, 5'd0, 5'b11000, 6'b100000}, 64'h1);
    chk("R1 rs msb checked", {62'd0, res_valid, res_illegal}, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_legal("R2 word swap", 5'b00010, 6'b100000, 0);
        t_legal("R3 dword swap", 5'b00010, 6'b100100, 1);
        t_legal("R4 halfword reverse", 5'b00101, 6'b100100, 2);
        t_legal("R5 byte sext", 5'b10000, 6'b100000, 3);
        t_legal("R6 half sext", 5'b11000, 6'b100000, 4);
        t_illegal();
        t_foreign();
        t_idle();
        t_fields();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule